// File: doc/BRIEF.md
# Register File with Constant Generator

A sixteen-entry register bank for a small processor core. It offers two combinational read ports, one general write port, a flag-update port fed by the ALU, and a step path that moves the program counter or stack pointer by two. Four entries behave specially. Entry 0 holds the program counter and entry 1 holds the stack pointer, and both are kept even. Entry 2 is the status word. Entry 3 is a constant zero source that ignores writes.

Each read port takes a 2-bit addressing-mode field next to its register select. When a read selects entry 3, or selects entry 2 in one of the two pointer modes, the port returns a generated small constant in place of the register contents. This lets the decoder get common immediates without a memory fetch. The block also exports the program counter, stack pointer and status word. It exports an interrupt-enable line that copies the status enable bit one cycle late.

Top module: `regbank_cg`

## Requirements
- R1: While `rst_n` is low, every entry clears to zero and `gie_q` is low on the next rising edge.
- R2: A read of entries 0, 1 or 4 to 15 in any mode returns the stored value in the same cycle. A read of entry 2 in mode 0 or 1 also returns the stored value in the same cycle.
- R3: Bit 0 of entries 0 and 1 is always zero. A write or step that would set it stores it cleared.
- R4: A read of entry 3 in mode 0 returns zero. Writes that target entry 3 change no output and no read value.
- R5: In mode 2, entry 2 reads as 4, and in mode 3 it reads as 8. Entry 3 reads as 1 in mode 1, as 2 in mode 2, and as all ones in mode 3.
- R6: When `wr_en` is high, entry `wr_sel` takes `wr_data` at the rising edge.
- R7: When `flg_en` is high, status bits 0, 1, 2 and 8 take `flg_nzcv[0]`, `[1]`, `[2]` and `[3]` at the edge. These are carry, zero, negative and overflow. All four change together and every other status bit is kept.
- R8: A general write to entry 2 in the same cycle as `flg_en` stores `wr_data` whole, and the flag update is dropped.
- R9: When `inc_en` is high, the entry picked by `inc_sp` changes at the edge. `inc_sp`=1 picks entry 1 and `inc_sp`=0 picks entry 0. The entry gains 2 when `inc_dn` is 0 and loses 2 when `inc_dn` is 1, wrapping modulo 2^16.
- R10: If the general write and the step target the same entry in one cycle, only the write takes effect. If they target different entries, both take effect.
- R11: `gie_q` equals the value that status bit 3 held one cycle earlier, for both rising and falling changes.
- R12: `pc_q`, `sp_q` and `sr_q` always show the current contents of entries 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_a_sel | input | 4 | Read port A register select |
| rd_a_mode | input | 2 | Read port A addressing mode |
| rd_a_data | output | 16 | Read port A data |
| rd_b_sel | input | 4 | Read port B register select |
| rd_b_mode | input | 2 | Read port B addressing mode |
| rd_b_data | output | 16 | Read port B data |
| wr_en | input | 1 | General write enable |
| wr_sel | input | 4 | General write target |
| wr_data | input | 16 | General write data |
| flg_en | input | 1 | Flag update enable |
| flg_nzcv | input | 4 | Flags {V,N,Z,C} |
| inc_en | input | 1 | Pointer step enable |
| inc_sp | input | 1 | Step target: 1 stack pointer, 0 program counter |
| inc_dn | input | 1 | Step direction: 1 subtract 2, 0 add 2 |
| pc_q | output | 16 | Program counter |
| sp_q | output | 16 | Stack pointer |
| sr_q | output | 16 | Status word |
| gie_q | output | 1 | Interrupt enable, one cycle behind status bit 3 |

## Verification
The bench builds the block with its defaults: 16-bit data and sixteen entries. At this size every pairing of the 16 selects with the 4 modes is swept on both read ports after each phase, and every entry is written with an odd pattern. Step wrap-around at both ends of the 16-bit range can be reached in one cycle. A long run of mixed random cycles, checked against a bench model, then covers the collisions between the write, flag and step paths.

// File: rtl/rf_pkg.sv
package rf_pkg;
  // fixed entry roles
  localparam int IDX_PC = 0;
  localparam int IDX_SP = 1;
  localparam int IDX_SR = 2;
  localparam int IDX_CG = 3;
  // status word bit positions
  localparam int SR_C   = 0;
  localparam int SR_Z   = 1;
  localparam int SR_N   = 2;
  localparam int SR_GIE = 3;
  localparam int SR_V   = 8;

  // does this select/mode pair produce a constant
  function automatic logic cg_active(input int unsigned sel, input logic [1:0] mode);
    return (sel == IDX_CG) || (sel == IDX_SR && mode[1]);
  endfunction

  // constant value, -1 truncates to all ones at any width
  function automatic int cg_value(input int unsigned sel, input logic [1:0] mode);
    if (sel == IDX_SR) return mode[0] ? 8 : 4;
    case (mode)
      2'd0:    return 0;
      2'd1:    return 1;
      2'd2:    return 2;
      default: return -1;
    endcase
  endfunction

  // pointer step amount
  function automatic int ptr_step(input logic dn);
    return dn ? -2 : 2;
  endfunction
endpackage

// File: rtl/rf_const_gen.sv
module rf_const_gen #(
  parameter int DATA_W = 16,
  parameter int AW     = 4
) (
  input  logic [AW-1:0]     sel,
  input  logic [1:0]        mode,
  output logic              hit,
  output logic [DATA_W-1:0] value
);
  import rf_pkg::*;
  assign hit   = cg_active(int'(sel), mode);
  assign value = DATA_W'(cg_value(int'(sel), mode));
endmodule

// File: rtl/rf_status.sv
module rf_status #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              flg_en,
  input  logic [3:0]        flg_nzcv,
  output logic [DATA_W-1:0] sr_q,
  output logic              gie_q
);
  import rf_pkg::*;

  // flag side effect actually taken this cycle
  logic flag_take;
  assign flag_take = flg_en && !wr_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q  <= '0;
      gie_q <= 1'b0;
    end else begin
      gie_q <= sr_q[SR_GIE];
      if (wr_hit) begin
        sr_q <= wr_data;
      end else if (flag_take) begin
        sr_q[SR_C] <= flg_nzcv[0];
        sr_q[SR_Z] <= flg_nzcv[1];
        sr_q[SR_N] <= flg_nzcv[2];
        sr_q[SR_V] <= flg_nzcv[3];
      end
    end
  end

  // R8
  sr_wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> sr_q == $past(wr_data));

  // R11
  gie_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gie_q == $past(sr_q[SR_GIE]));

  // R7
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_take |=> (sr_q[SR_GIE] == $past(sr_q[SR_GIE])) && (sr_q[SR_N] == $past(flg_nzcv[2])));
endmodule

// File: rtl/rf_gpr_array.sv
module rf_gpr_array #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 16,
  parameter int AW       = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [AW-1:0]                    wr_sel,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic                             inc_en,
  input  logic                             inc_sp,
  input  logic                             inc_dn,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);
  import rf_pkg::*;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
    if (i == IDX_SR || i == IDX_CG) begin : g_none
      assign regs_q[i] = '0;
    end else begin : g_live
      logic              wr_hit, inc_hit;
      logic [DATA_W-1:0] q, nxt;
      assign wr_hit  = wr_en && (wr_sel == AW'(i));
      assign inc_hit = inc_en && (i <= IDX_SP) && (int'(inc_sp) == i);
      always_comb begin
        nxt = q;
        if (wr_hit)       nxt = wr_data;
        else if (inc_hit) nxt = q + DATA_W'(ptr_step(inc_dn));
        if (i <= IDX_SP)  nxt[0] = 1'b0;
      end
      always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
      end
      assign regs_q[i] = q;
    end
  end

  // R3
  ptr_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !regs_q[IDX_PC][0] && !regs_q[IDX_SP][0]);

  // R10
  wr_over_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && inc_en && !inc_sp && wr_sel == AW'(IDX_PC))
      |=> regs_q[IDX_PC][DATA_W-1:1] == $past(wr_data[DATA_W-1:1]));
endmodule

// File: rtl/regbank_cg.sv
module regbank_cg #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [$clog2(NUM_REGS)-1:0] rd_a_sel,
  input  logic [1:0]                  rd_a_mode,
  output logic [DATA_W-1:0]           rd_a_data,
  input  logic [$clog2(NUM_REGS)-1:0] rd_b_sel,
  input  logic [1:0]                  rd_b_mode,
  output logic [DATA_W-1:0]           rd_b_data,
  input  logic                        wr_en,
  input  logic [$clog2(NUM_REGS)-1:0] wr_sel,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic                        flg_en,
  input  logic [3:0]                  flg_nzcv,
  input  logic                        inc_en,
  input  logic                        inc_sp,
  input  logic                        inc_dn,
  output logic [DATA_W-1:0]           pc_q,
  output logic [DATA_W-1:0]           sp_q,
  output logic [DATA_W-1:0]           sr_q,
  output logic                        gie_q
);
  import rf_pkg::*;
  localparam int AW     = $clog2(NUM_REGS);
  localparam int NPORTS = 2;

  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
  logic sr_wr;
  assign sr_wr = wr_en && (wr_sel == AW'(IDX_SR));

  rf_gpr_array #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .AW(AW)) u_arr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .inc_en(inc_en), .inc_sp(inc_sp), .inc_dn(inc_dn), .regs_q(regs_q));

  rf_status #(.DATA_W(DATA_W)) u_sr (
    .clk(clk), .rst_n(rst_n), .wr_hit(sr_wr), .wr_data(wr_data),
    .flg_en(flg_en), .flg_nzcv(flg_nzcv), .sr_q(sr_q), .gie_q(gie_q));

  // read ports
  logic [NPORTS-1:0][AW-1:0]     rsel;
  logic [NPORTS-1:0][1:0]        rmode;
  logic [NPORTS-1:0][DATA_W-1:0] rdat, cg_val;
  logic [NPORTS-1:0]             cg_hit;
  assign rsel  = {rd_b_sel, rd_a_sel};
  assign rmode = {rd_b_mode, rd_a_mode};

  for (genvar p = 0; p < NPORTS; p++) begin : g_rd
    rf_const_gen #(.DATA_W(DATA_W), .AW(AW)) u_cg (
      .sel(rsel[p]), .mode(rmode[p]), .hit(cg_hit[p]), .value(cg_val[p]));
    assign rdat[p] = cg_hit[p] ? cg_val[p]
                   : (rsel[p] == AW'(IDX_SR)) ? sr_q : regs_q[rsel[p]];
  end

  assign rd_a_data = rdat[0];
  assign rd_b_data = rdat[1];
  assign pc_q      = regs_q[IDX_PC];
  assign sp_q      = regs_q[IDX_SP];

  // R4
  r3_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_sel == AW'(IDX_CG) && rd_a_mode == 2'd0) |-> rd_a_data == '0);

  // R5
  r2_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_sel == AW'(IDX_SR) && rd_a_mode[1]) |-> rd_a_data == (rd_a_mode[0] ? DATA_W'(8) : DATA_W'(4)));

  // R2
  r2_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_sel == AW'(IDX_SR) && !rd_b_mode[1]) |-> rd_b_data == sr_q);
endmodule

// File: tb/tb_regbank_cg.sv
`timescale 1ns/1ps
module tb_regbank_cg;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic [3:0] rd_a_sel, rd_b_sel, wr_sel;
  logic [1:0] rd_a_mode, rd_b_mode;
  logic [15:0] rd_a_data, rd_b_data, wr_data, pc_q, sp_q, sr_q;
  logic wr_en, flg_en, inc_en, inc_sp, inc_dn, gie_q;
  logic [3:0] flg_nzcv;

  regbank_cg dut (.*);

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] m [16];
  logic mgie;

  function automatic logic [15:0] exp_rd(int s, logic [1:0] md);
    if (s == 3) return (md == 0) ? 16'h0 : (md == 1) ? 16'h1 : (md == 2) ? 16'h2 : 16'hFFFF;
    if (s == 2 && md[1]) return md[0] ? 16'h8 : 16'h4;
    return m[s];
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_outs(string tag);
    chk({tag, " R12 pc"}, pc_q, m[0]);
    chk({tag, " R12 sp"}, sp_q, m[1]);
    chk({tag, " R12 sr"}, sr_q, m[2]);
    chk({tag, " R11 gie"}, {15'd0, gie_q}, {15'd0, mgie});
  endtask

  task automatic sweep(string tag);
    for (int s = 0; s < 16; s++) begin
      for (int md = 0; md < 4; md++) begin
        rd_a_sel = 4'(s); rd_a_mode = 2'(md);
        rd_b_sel = 4'(15 - s); rd_b_mode = ~2'(md);
        #0.01;
        chk({tag, (s == 3 && md == 0) ? " R4 rdA" : (s == 3 || (s == 2 && md >= 2)) ? " R5 rdA" : " R2 rdA"},
            rd_a_data, exp_rd(s, 2'(md)));
        chk({tag, " R2/R5 rdB"}, rd_b_data, exp_rd(15 - s, ~2'(md)));
      end
    end
  endtask

  task automatic cyc(string tag, logic we, logic [3:0] ws, logic [15:0] wd,
                     logic fe, logic [3:0] fv, logic ie, logic isp, logic idn);
    logic ng;
    int t;
    @(negedge clk);
    wr_en = we; wr_sel = ws; wr_data = wd;
    flg_en = fe; flg_nzcv = fv; inc_en = ie; inc_sp = isp; inc_dn = idn;
    ng = m[2][3];
    if (fe && !(we && ws == 2)) begin
      m[2][0] = fv[0]; m[2][1] = fv[1]; m[2][2] = fv[2]; m[2][8] = fv[3];
    end
    if (ie) begin
      t = isp ? 1 : 0;
      if (!(we && ws == 4'(t))) m[t] = m[t] + (idn ? 16'hFFFE : 16'h0002);
    end
    if (we && ws != 3) begin
      m[ws] = wd;
      if (ws <= 1) m[ws][0] = 1'b0;
    end
    mgie = ng;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; flg_en = 0; inc_en = 0;
    check_outs(tag);
  endtask

  initial begin
    rst_n = 0; wr_en = 0; flg_en = 0; inc_en = 0; inc_sp = 0; inc_dn = 0;
    wr_sel = 0; wr_data = 0; flg_nzcv = 0;
    rd_a_sel = 0; rd_b_sel = 0; rd_a_mode = 0; rd_b_mode = 0;
    for (int i = 0; i < 16; i++) m[i] = 16'h0;
    mgie = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    check_outs("R1 reset");
    sweep("R1 reset");

    // R6 R3 R4: write an odd pattern to every entry
    for (int r = 0; r < 16; r++)
      cyc("R6 write", 1, 4'(r), (16'hA5C3 ^ (16'(r) * 16'h1111)) | 16'h1, 0, 0, 0, 0, 0);
    sweep("R6 after writes");

    // R7 flag update keeps other bits
    cyc("R7 flags", 0, 0, 0, 1, 4'b1010, 0, 0, 0);
    cyc("R7 flags", 0, 0, 0, 1, 4'b0101, 0, 0, 0);
    // R8 write to r2 beats flags, sets GIE
    cyc("R8 prio", 1, 4'd2, 16'h0008, 1, 4'b1111, 0, 0, 0);
    cyc("R11 rise", 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R8 clr", 1, 4'd2, 16'h0000, 1, 4'b1111, 0, 0, 0);
    cyc("R11 fall", 0, 0, 0, 0, 0, 0, 0, 0);
    // R9 wrap both ways
    cyc("R9 setpc", 1, 4'd0, 16'hFFFF, 0, 0, 0, 0, 0);
    cyc("R9 pc up wrap", 0, 0, 0, 0, 0, 1, 0, 0);
    cyc("R9 sp clr", 1, 4'd1, 16'h0000, 0, 0, 0, 0, 0);
    cyc("R9 sp dn wrap", 0, 0, 0, 0, 0, 1, 1, 1);
    cyc("R9 pc dn wrap", 0, 0, 0, 0, 0, 1, 0, 1);
    // R10 collisions
    cyc("R10 same pc", 1, 4'd0, 16'h1235, 0, 0, 1, 0, 0);
    cyc("R10 same sp", 1, 4'd1, 16'h4441, 0, 0, 1, 1, 1);
    cyc("R10 diff", 1, 4'd5, 16'hBEEF, 0, 0, 1, 1, 0);
    // R4 write to r3 discarded
    cyc("R4 r3 wr", 1, 4'd3, 16'hFFFF, 0, 0, 0, 0, 0);
    sweep("R10 after directed");

    // random mix
    for (int k = 0; k < 3000; k++) begin
      cyc("R6-mix", 1'($urandom), 4'($urandom), 16'($urandom), 1'($urandom),
          4'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      if (k % 200 == 0) sweep("R2 mix");
    end
    sweep("R5 final");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule